// File: doc/BRIEF.md
# Floating-Point Exception Status and NaN Substitution Unit

This unit sits after a single-precision arithmetic datapath. Each time the datapath finishes an operation, it sends a one-cycle strobe. The strobe carries the operation class, the three operand words, the raw result word and six raw exception indications. The unit classifies the operands, adjusts the exceptions according to the operation, and replaces a generated NaN with a code that identifies which kind of operation produced it. It registers the final result one cycle after the strobe. The same edge folds the adjusted exceptions into six status bits:

- `stFs` is a summary bit, rewritten by every operation.
- `stFi`, `stFv`, `stFz`, `stFu` and `stFx` are sticky.

A second strobe carries a 16-bit flag-update word. Software uses it to write or clear the status bits under per-bit enables. When both strobes arrive in the same cycle, the update word decides the status bits and the arithmetic result is still delivered.

Top module: `fpu_flag_unit`

## Requirements
- R1: After reset all six status bits, `resOut` and `resOutValid` are 0.
- R2: `rawFlags` bit order is invalid[0], overflow[1], underflow[2], output-denormal[3], divide-by-zero[4], inexact[5]. For any operation, invalid sets `stFi`, overflow sets `stFv` and divide-by-zero sets `stFz`. None of these bits is cleared by a later arithmetic operation.
- R3: Underflow or output-denormal sets `stFu`. Inexact or output-denormal sets `stFx`. Both are sticky like R2.
- R4: `stFs` becomes 1 when any adjusted flag is present. With no flag, `stFs` becomes 0 and the other five bits keep their values. Op classes 9 to 15 pass the raw result and raw flags through unchanged.
- R5: For add (op 0) and subtract (op 1), an invalid flag with neither `opA` nor `opB` a NaN gives result 0x7FC00001. For multiply (op 2) the result is 0x7FC00002, and for divide (op 3) it is 0x7FC00008. In every other case the raw result appears on `resOut`, with `resOutValid` high, one cycle after `resValid`.
- R6: For the square-root class (op 6), invalid with `opA` not a NaN gives 0x7FC00004.
- R7: For fused multiply-add (op 4) and its subtract variant (op 5), invalid with any operand a NaN gives 0x7FC00000.
- R8: For op 4 and op 5, invalid with no NaN operand, with one of `opA` and `opB` infinite and the other zero, gives 0x7FC00002. A denormal counts as zero here.
- R9: For op 4 and op 5, invalid with no NaN operand and no infinity-times-zero case gives 0x7FC00001 when the product is infinite, `opC` is infinite, and the product sign differs from the effective addend sign. For op 5 the effective addend sign is the inverse of the `opC` sign. Otherwise the raw result passes.
- R10: For signed (op 7) and unsigned (op 8) float-to-integer conversion, invalid suppresses inexact in the status update. A NaN `opA` then gives result 0.
- R11: For op 8 with no raw invalid, an `opA` below zero (sign set and not ±0) gives result 0 and invalid as the only flag.
- R12: On an update strobe, `stFs`, `stFi`, `stFv`, `stFz` and `stFu` are loaded with value AND enable. Their value bits are 7, 6, 5, 4, 3 and their enable bits are 15, 14, 13, 12, 11.
- R13: On an update strobe, `stFx` is loaded from bit 2 when bit 10 is 1, and is unchanged when bit 10 is 0.
- R14: When `resValid` and `updValid` occur in the same cycle, the status bits follow only the update word, and the result is still registered as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resValid | input | 1 | One-cycle strobe: an operation has completed |
| resOp | input | 4 | Operation class |
| opA | input | 32 | First operand word |
| opB | input | 32 | Second operand word |
| opC | input | 32 | Addend operand word for fused ops |
| rawRes | input | 32 | Raw result word from the datapath |
| rawFlags | input | 6 | Raw exception indications |
| updValid | input | 1 | One-cycle strobe for the flag-update word |
| updWord | input | 16 | Flag-update values and enables |
| resOut | output | 32 | Final result word |
| resOutValid | output | 1 | `resOut` holds a new result |
| stFs | output | 1 | Summary exception bit |
| stFi | output | 1 | Sticky invalid |
| stFv | output | 1 | Sticky overflow |
| stFz | output | 1 | Sticky divide-by-zero |
| stFu | output | 1 | Sticky underflow |
| stFx | output | 1 | Sticky inexact |

## Verification
The bench targets the fused-op NaN ordering, covering each of these mistakes:
- A design that tests the sign combination before the infinity-times-zero case returns the add code where the multiply code belongs.
- A design that forgets the addend inversion for op 5 gets every opposite-sign infinity case wrong.
- A design that counts denormals as nonzero misses infinity times a denormal.

It also covers these status and conversion cases:
- Negative zero and a negative input to unsigned conversion separate a correct sign test from one that treats −0 as negative.
- Conversions that carry both invalid and inexact expose a design that still sets `stFx`.
- Update words with bit 10 clear, and update strobes that collide with arithmetic strobes, expose an unconditional `stFx` load and a wrong priority.

Random operands are drawn from a pool of zeros, infinities, quiet and signalling NaNs, denormals and ordinary values, so that these paths are crossed many times.

// File: rtl/fpu_flag_pkg.sv
package fpu_flag_pkg;

  localparam int WORD_W     = 32;
  localparam int EXP_W      = 8;
  localparam int MAN_W      = 23;
  localparam int OP_W       = 4;
  localparam int UPD_W      = 16;
  localparam int RAW_FLAG_N = 6;
  localparam int STAT_N     = 6;
  localparam int OPND_N     = 3;

  // update word: value bit for status index i is UPD_VAL_TOP - i, enable is +UPD_EN_OFS
  localparam int UPD_VAL_TOP = 7;
  localparam int UPD_EN_OFS  = 8;

  // raw flag positions
  localparam int FL_INV = 0;
  localparam int FL_OVF = 1;
  localparam int FL_UNF = 2;
  localparam int FL_DEN = 3;
  localparam int FL_DVZ = 4;
  localparam int FL_INX = 5;

  // status positions
  localparam int ST_FS = 0;
  localparam int ST_FI = 1;
  localparam int ST_FV = 2;
  localparam int ST_FZ = 3;
  localparam int ST_FU = 4;
  localparam int ST_FX = 5;

  localparam logic [WORD_W-1:0] NAN_DEFAULT = 32'h7FC0_0000;
  localparam logic [WORD_W-1:0] NAN_ADD     = 32'h7FC0_0001;
  localparam logic [WORD_W-1:0] NAN_MUL     = 32'h7FC0_0002;
  localparam logic [WORD_W-1:0] NAN_SQRT    = 32'h7FC0_0004;
  localparam logic [WORD_W-1:0] NAN_DIV     = 32'h7FC0_0008;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_DIV  = 4'd3,
    OP_FMA  = 4'd4,
    OP_FMS  = 4'd5,
    OP_SQRT = 4'd6,
    OP_F2I  = 4'd7,
    OP_F2U  = 4'd8,
    OP_PASS = 4'd9
  } opClass_e;

  typedef enum logic [2:0] {
    SEL_RAW,
    SEL_ZERO,
    SEL_QNAN,
    SEL_ADDNAN,
    SEL_MULNAN,
    SEL_DIVNAN,
    SEL_SQRTNAN
  } resSel_e;

  typedef struct packed {
    logic              resLoad;
    resSel_e           resSel;
    logic              statLoad;
    logic [STAT_N-1:0] statSet;
    logic              updLoad;
    logic [STAT_N-1:0] updVal;
    logic [STAT_N-1:0] updEn;
  } ctrlStrobe_t;

endpackage

// File: rtl/fpu_opnd_class.sv
module fpu_opnd_class
  import fpu_flag_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              isNan,
  output logic              isInf,
  output logic              isZeroDn,
  output logic              isNeg
);

  localparam int EXP_LO = MAN_W;
  localparam int EXP_HI = MAN_W + EXP_W - 1;

  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic             expMax;

  assign expField = word[EXP_HI:EXP_LO];
  assign manField = word[MAN_W-1:0];
  assign expMax   = &expField;

  assign isNan    = expMax && (manField != '0);
  assign isInf    = expMax && (manField == '0);
  assign isZeroDn = (expField == '0);
  assign isNeg    = word[WORD_W-1];

endmodule

// File: rtl/fpu_flag_ctrl.sv
module fpu_flag_ctrl
  import fpu_flag_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  resValid,
  input  logic [OP_W-1:0]       resOp,
  input  logic [WORD_W-1:0]     opA,
  input  logic [WORD_W-1:0]     opB,
  input  logic [WORD_W-1:0]     opC,
  input  logic [RAW_FLAG_N-1:0] rawFlags,
  input  logic                  updValid,
  input  logic [UPD_W-1:0]      updWord,
  output ctrlStrobe_t           strobe
);

  logic [WORD_W-1:0] opnd [OPND_N];
  logic [OPND_N-1:0] cNan, cInf, cZero, cNeg;

  assign opnd[0] = opA;
  assign opnd[1] = opB;
  assign opnd[2] = opC;

  for (genvar k = 0; k < OPND_N; k++) begin : g_cls
    fpu_opnd_class u_cls (
      .word    (opnd[k]),
      .isNan   (cNan[k]),
      .isInf   (cInf[k]),
      .isZeroDn(cZero[k]),
      .isNeg   (cNeg[k])
    );
  end

  opClass_e              opCls;
  logic [RAW_FLAG_N-1:0] effFlags;
  resSel_e               sel;
  logic                  aBelowZero;
  logic                  invIn;
  logic                  addendNeg;

  assign opCls      = opClass_e'(resOp);
  assign invIn      = rawFlags[FL_INV];
  assign aBelowZero = opA[WORD_W-1] && (opA[WORD_W-2:0] != '0);
  assign addendNeg  = cNeg[2] ^ (opCls == OP_FMS);

  always_comb begin
    effFlags = rawFlags;
    sel      = SEL_RAW;
    unique case (opCls)
      OP_ADD, OP_SUB: if (invIn && !cNan[0] && !cNan[1]) sel = SEL_ADDNAN;
      OP_MUL:         if (invIn && !cNan[0] && !cNan[1]) sel = SEL_MULNAN;
      OP_DIV:         if (invIn && !cNan[0] && !cNan[1]) sel = SEL_DIVNAN;
      OP_SQRT:        if (invIn && !cNan[0]) sel = SEL_SQRTNAN;
      OP_FMA, OP_FMS: begin
        if (invIn) begin
          if (|cNan) begin
            sel = SEL_QNAN;
          end else if ((cInf[0] && cZero[1]) || (cZero[0] && cInf[1])) begin
            sel = SEL_MULNAN;
          end else if ((cInf[0] || cInf[1]) && cInf[2]
                       && ((cNeg[0] ^ cNeg[1]) != addendNeg)) begin
            sel = SEL_ADDNAN;
          end
        end
      end
      OP_F2I: begin
        if (invIn) begin
          effFlags[FL_INX] = 1'b0;
          if (cNan[0]) sel = SEL_ZERO;
        end
      end
      OP_F2U: begin
        if (invIn) begin
          effFlags[FL_INX] = 1'b0;
          if (cNan[0]) sel = SEL_ZERO;
        end else if (aBelowZero) begin
          effFlags         = '0;
          effFlags[FL_INV] = 1'b1;
          sel              = SEL_ZERO;
        end
      end
      default: sel = SEL_RAW;
    endcase
  end

  logic [STAT_N-1:0] setVec;
  assign setVec[ST_FS] = |effFlags;
  assign setVec[ST_FI] = effFlags[FL_INV];
  assign setVec[ST_FV] = effFlags[FL_OVF];
  assign setVec[ST_FZ] = effFlags[FL_DVZ];
  assign setVec[ST_FU] = effFlags[FL_UNF] | effFlags[FL_DEN];
  assign setVec[ST_FX] = effFlags[FL_INX] | effFlags[FL_DEN];

  logic [STAT_N-1:0] uVal, uEn;
  for (genvar i = 0; i < STAT_N; i++) begin : g_upd
    assign uVal[i] = updWord[UPD_VAL_TOP - i];
    assign uEn[i]  = updWord[UPD_VAL_TOP - i + UPD_EN_OFS];
  end

  assign strobe.resLoad  = resValid;
  assign strobe.resSel   = sel;
  assign strobe.statLoad = resValid && !updValid;
  assign strobe.statSet  = setVec;
  assign strobe.updLoad  = updValid;
  assign strobe.updVal   = uVal;
  assign strobe.updEn    = uEn;

  AST_CONV_NO_INEXACT: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && (resOp == OP_F2I || resOp == OP_F2U) && invIn && !rawFlags[FL_DEN])
      |-> !strobe.statSet[ST_FX]); // R10
  AST_UPD_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> !strobe.statLoad); // R14
  AST_SEL_ONLY_ON_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resOp <= OP_DIV && !invIn) |-> (strobe.resSel == SEL_RAW)); // R5

endmodule

// File: rtl/fpu_flag_dp.sv
module fpu_flag_dp
  import fpu_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] rawRes,
  output logic [WORD_W-1:0] resOut,
  output logic              resOutValid,
  output logic [STAT_N-1:0] stat
);

  logic [WORD_W-1:0] resNext;

  always_comb begin
    unique case (strobe.resSel)
      SEL_ZERO:    resNext = '0;
      SEL_QNAN:    resNext = NAN_DEFAULT;
      SEL_ADDNAN:  resNext = NAN_ADD;
      SEL_MULNAN:  resNext = NAN_MUL;
      SEL_DIVNAN:  resNext = NAN_DIV;
      SEL_SQRTNAN: resNext = NAN_SQRT;
      default:     resNext = rawRes;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resOut      <= '0;
      resOutValid <= 1'b0;
    end else begin
      resOutValid <= strobe.resLoad;
      if (strobe.resLoad) resOut <= resNext;
    end
  end

  for (genvar i = 0; i < STAT_N; i++) begin : g_stat
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stat[i] <= 1'b0;
      end else if (strobe.updLoad) begin
        if (i == ST_FX) begin
          if (strobe.updEn[i]) stat[i] <= strobe.updVal[i];
        end else begin
          stat[i] <= strobe.updVal[i] & strobe.updEn[i];
        end
      end else if (strobe.statLoad) begin
        if (i == ST_FS) stat[i] <= strobe.statSet[i];
        else            stat[i] <= stat[i] | strobe.statSet[i];
      end
    end
  end

  AST_FS_CLEAR_NOFLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.statLoad && strobe.statSet == '0) |=> !stat[ST_FS]); // R4
  AST_FI_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.updLoad && stat[ST_FI]) |=> stat[ST_FI]); // R2
  AST_FX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.updLoad && !strobe.updEn[ST_FX]) |=> $stable(stat[ST_FX])); // R13
  AST_ADD_NAN_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.resLoad && strobe.resSel == SEL_ADDNAN) |=> (resOut == NAN_ADD)); // R5
  AST_UPD_FS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.updLoad |=> (stat[ST_FS] == $past(strobe.updVal[ST_FS] & strobe.updEn[ST_FS]))); // R12

endmodule

// File: rtl/fpu_flag_unit.sv
module fpu_flag_unit
  import fpu_flag_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  resValid,
  input  logic [OP_W-1:0]       resOp,
  input  logic [WORD_W-1:0]     opA,
  input  logic [WORD_W-1:0]     opB,
  input  logic [WORD_W-1:0]     opC,
  input  logic [WORD_W-1:0]     rawRes,
  input  logic [RAW_FLAG_N-1:0] rawFlags,
  input  logic                  updValid,
  input  logic [UPD_W-1:0]      updWord,
  output logic [WORD_W-1:0]     resOut,
  output logic                  resOutValid,
  output logic                  stFs,
  output logic                  stFi,
  output logic                  stFv,
  output logic                  stFz,
  output logic                  stFu,
  output logic                  stFx
);

  ctrlStrobe_t       strobe;
  logic [STAT_N-1:0] stat;

  fpu_flag_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .resValid (resValid),
    .resOp    (resOp),
    .opA      (opA),
    .opB      (opB),
    .opC      (opC),
    .rawFlags (rawFlags),
    .updValid (updValid),
    .updWord  (updWord),
    .strobe   (strobe)
  );

  fpu_flag_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rawRes      (rawRes),
    .resOut      (resOut),
    .resOutValid (resOutValid),
    .stat        (stat)
  );

  assign stFs = stat[ST_FS];
  assign stFi = stat[ST_FI];
  assign stFv = stat[ST_FV];
  assign stFz = stat[ST_FZ];
  assign stFu = stat[ST_FU];
  assign stFx = stat[ST_FX];

endmodule

// File: tb/fpu_flag_unit_tb_top.sv
module fpu_flag_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resValid = 1'b0;
  logic [3:0]  resOp = '0;
  logic [31:0] opA = '0, opB = '0, opC = '0, rawRes = '0;
  logic [5:0]  rawFlags = '0;
  logic        updValid = 1'b0;
  logic [15:0] updWord = '0;
  logic [31:0] resOut;
  logic        resOutValid;
  logic        stFs, stFi, stFv, stFz, stFu, stFx;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  logic [5:0] expStat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_flag_unit dut_i (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resOp(resOp),
    .opA(opA), .opB(opB), .opC(opC), .rawRes(rawRes), .rawFlags(rawFlags),
    .updValid(updValid), .updWord(updWord), .resOut(resOut),
    .resOutValid(resOutValid), .stFs(stFs), .stFi(stFi), .stFv(stFv),
    .stFz(stFz), .stFu(stFu), .stFx(stFx)
  );

  function automatic bit fNan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic bit fInf(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] == 0);
  endfunction
  function automatic bit fZd(input logic [31:0] x);
    return x[30:23] == 8'h00;
  endfunction

  // expected result and adjusted flags (inv0 ovf1 unf2 den3 dvz4 inx5)
  task automatic modelArith(input logic [3:0] op, input logic [31:0] a, b, c, raw,
                            input logic [5:0] fl, output logic [31:0] r,
                            output logic [5:0] eff);
    bit inv = fl[0];
    bit sB;
    r = raw;
    eff = fl;
    case (op)
      4'd0, 4'd1: if (inv && !fNan(a) && !fNan(b)) r = 32'h7FC00001;
      4'd2:       if (inv && !fNan(a) && !fNan(b)) r = 32'h7FC00002;
      4'd3:       if (inv && !fNan(a) && !fNan(b)) r = 32'h7FC00008;
      4'd6:       if (inv && !fNan(a)) r = 32'h7FC00004;
      4'd4, 4'd5: begin
        sB = c[31] ^ (op == 4'd5);
        if (inv) begin
          if (fNan(a) || fNan(b) || fNan(c)) r = 32'h7FC00000;
          else if ((fInf(a) && fZd(b)) || (fZd(a) && fInf(b))) r = 32'h7FC00002;
          else if ((fInf(a) || fInf(b)) && fInf(c) && ((a[31] ^ b[31]) != sB))
            r = 32'h7FC00001;
        end
      end
      4'd7: if (inv) begin eff[5] = 1'b0; if (fNan(a)) r = 0; end
      4'd8: begin
        if (inv) begin eff[5] = 1'b0; if (fNan(a)) r = 0; end
        else if (a[31] && a[30:0] != 0) begin eff = 6'b000001; r = 0; end
      end
      default: ;
    endcase
  endtask

  function automatic logic [5:0] applyArith(input logic [5:0] s, input logic [5:0] e);
    logic [5:0] n = s;
    n[0] = |e;
    n[1] = s[1] | e[0];
    n[2] = s[2] | e[1];
    n[3] = s[3] | e[4];
    n[4] = s[4] | e[2] | e[3];
    n[5] = s[5] | e[5] | e[3];
    return n;
  endfunction

  function automatic logic [5:0] applyUpd(input logic [5:0] s, input logic [15:0] w);
    logic [5:0] n = s;
    n[0] = w[7] & w[15];
    n[1] = w[6] & w[14];
    n[2] = w[5] & w[13];
    n[3] = w[4] & w[12];
    n[4] = w[3] & w[11];
    if (w[10]) n[5] = w[2];
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] statNow();
    return {stFx, stFu, stFz, stFv, stFi, stFs};
  endfunction

  // one cycle: optional arithmetic strobe, optional update strobe; checks after the edge
  task automatic step(input bit doArith, input logic [3:0] op, input logic [31:0] a, b, c,
                      raw, input logic [5:0] fl, input bit doUpd, input logic [15:0] w,
                      input bit useExp, input logic [31:0] expLit,
                      input string resTag, input string statTag);
    logic [31:0] r;
    logic [5:0]  e;
    modelArith(op, a, b, c, raw, fl, r, e);
    if (useExp) r = expLit;
    if (doUpd)        expStat = applyUpd(expStat, w);
    else if (doArith) expStat = applyArith(expStat, e);
    resValid = doArith; resOp = op; opA = a; opB = b; opC = c; rawRes = raw;
    rawFlags = fl; updValid = doUpd; updWord = w;
    @(negedge clk);
    resValid = 1'b0; updValid = 1'b0;
    if (doArith) begin
      chk(resOutValid == 1'b1, resTag, {31'd0, resOutValid}, 32'd1);
      chk(resOut == r, resTag, resOut, r);
    end
    chk(statNow() == expStat, statTag, {26'd0, statNow()}, {26'd0, expStat});
  endtask

  task automatic arith(input logic [3:0] op, input logic [31:0] a, b, c, raw,
                       input logic [5:0] fl, input logic [31:0] expLit,
                       input string resTag, input string statTag);
    step(1'b1, op, a, b, c, raw, fl, 1'b0, 16'h0, 1'b1, expLit, resTag, statTag);
  endtask

  task automatic upd(input logic [15:0] w, input string tag);
    step(1'b0, 4'd9, 0, 0, 0, 0, 6'd0, 1'b1, w, 1'b0, 32'd0, tag, tag);
  endtask

  function automatic logic [31:0] pickOpnd();
    case ($urandom % 10)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h7F80_0000;
      3: return 32'hFF80_0000;
      4: return 32'h7FC0_0000 | ($urandom & 32'h003F_FFFF);
      5: return 32'h7F80_0001 | ($urandom & 32'h001F_FFFF);
      6: return ($urandom & 32'h807F_FFFF);
      7: return 32'h3F80_0000;
      8: return 32'hBF80_0000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(statNow() == 6'd0, "R1", {26'd0, statNow()}, 32'd0);
    chk(resOut == 32'd0 && !resOutValid, "R1", resOut, 32'd0);

    // R5 unique codes
    arith(4'd0, 32'h7F800000, 32'hFF800000, 0, 32'h7FC00000, 6'h01, 32'h7FC00001, "R5", "R2");
    arith(4'd1, 32'h7FC00123, 32'h3F800000, 0, 32'h7FC00123, 6'h01, 32'h7FC00123, "R5", "R2");
    arith(4'd2, 32'h7F800000, 32'h00000000, 0, 32'h7FC00000, 6'h01, 32'h7FC00002, "R5", "R2");
    arith(4'd3, 32'h00000000, 32'h80000000, 0, 32'h7FC00000, 6'h01, 32'h7FC00008, "R5", "R2");
    arith(4'd2, 32'h3F800000, 32'h40000000, 0, 32'h40000000, 6'h00, 32'h40000000, "R5", "R4");
    // R6
    arith(4'd6, 32'hBF800000, 0, 0, 32'h7FC00000, 6'h01, 32'h7FC00004, "R6", "R2");
    // R7 R8 R9
    arith(4'd4, 32'h3F800000, 32'h3F800000, 32'h7FC00000, 32'h12345678, 6'h01, 32'h7FC00000, "R7", "R2");
    arith(4'd4, 32'h7F800000, 32'h00000000, 32'h3F800000, 32'h7FC00000, 6'h01, 32'h7FC00002, "R8", "R2");
    arith(4'd5, 32'h00000001, 32'hFF800000, 32'h3F800000, 32'h7FC00000, 6'h01, 32'h7FC00002, "R8", "R2");
    arith(4'd4, 32'h7F800000, 32'h3F800000, 32'hFF800000, 32'h7FC00000, 6'h01, 32'h7FC00001, "R9", "R2");
    arith(4'd4, 32'h7F800000, 32'h3F800000, 32'h7F800000, 32'h11111111, 6'h01, 32'h11111111, "R9", "R2");
    arith(4'd5, 32'h7F800000, 32'h3F800000, 32'h7F800000, 32'h7FC00000, 6'h01, 32'h7FC00001, "R9", "R2");
    // clear all status, R12 R13
    upd(16'hFC00, "R12");
    // R10 conversion: invalid suppresses inexact, NaN -> 0
    arith(4'd7, 32'h7FC00000, 0, 0, 32'h80000000, 6'h21, 32'd0, "R10", "R10");
    chk(stFx == 1'b0, "R10", {31'd0, stFx}, 32'd0);
    arith(4'd8, 32'h7F800001, 0, 0, 32'hFFFFFFFF, 6'h21, 32'd0, "R10", "R10");
    upd(16'hFC00, "R12");
    // R11 negative to unsigned
    arith(4'd8, 32'hBF800000, 0, 0, 32'h00000000, 6'h20, 32'd0, "R11", "R11");
    chk(stFi == 1'b1 && stFx == 1'b0, "R11", {30'd0, stFi, stFx}, 32'd2);
    arith(4'd8, 32'h80000000, 0, 0, 32'h00000000, 6'h00, 32'd0, "R11", "R4");
    chk(stFs == 1'b0, "R11", {31'd0, stFs}, 32'd0);
    // R2 R3 R4
    upd(16'hFC00, "R12");
    arith(4'd9, 0, 0, 0, 32'hCAFEF00D, 6'h08, 32'hCAFEF00D, "R4", "R3");
    chk(stFu && stFx && !stFi, "R3", {26'd0, statNow()}, 32'h31);
    arith(4'd9, 0, 0, 0, 32'h1, 6'h12, 32'h1, "R4", "R2");
    arith(4'd9, 0, 0, 0, 32'h2, 6'h00, 32'h2, "R4", "R4");
    chk(!stFs && stFv && stFz, "R4", {26'd0, statNow()}, 32'h3C);
    // R12 R13 update variants
    upd(16'hFFFF, "R12");
    upd(16'h8080, "R12");
    upd(16'h0004, "R13");
    chk(stFx == 1'b1, "R13", {31'd0, stFx}, 32'd1);
    upd(16'h0400, "R13");
    chk(stFx == 1'b0, "R13", {31'd0, stFx}, 32'd0);
    // R14 collision
    step(1'b1, 4'd0, 32'h7F800000, 32'hFF800000, 0, 32'h7FC00000, 6'h3F, 1'b1, 16'hF800,
         1'b1, 32'h7FC00001, "R14", "R14");

    // random mix
    for (int n = 0; n < N_RANDOM; n++) begin
      logic [3:0]  op = 4'($urandom % 12);
      logic [31:0] a = pickOpnd(), b = pickOpnd(), c = pickOpnd();
      logic [5:0]  fl = 6'($urandom) & 6'($urandom);
      bit          doU = ($urandom % 8) == 0;
      bit          doA = ($urandom % 8) != 0;
      string       rt;
      case (op)
        4'd0, 4'd1, 4'd2, 4'd3: rt = "R5";
        4'd4, 4'd5: rt = "R9";
        4'd6: rt = "R6";
        4'd7: rt = "R10";
        4'd8: rt = "R11";
        default: rt = "R4";
      endcase
      step(doA, op, a, b, c, $urandom, fl, doU, 16'($urandom), 1'b0, 32'd0, rt,
           doU ? "R12" : "R3");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule